// File: doc/BRIEF.md
# SPI Master Pad Timing Skew Unit

This block sits between an SPI master's shift logic and its pads, and moves the serial data in time against the internal serial-clock edges. It is meant for links where pad and board delay eat a large share of a bit period. The outgoing data bit can be held back by zero to three source-clock cycles. The incoming data bit passes a two-flop synchronizer and then a delay of zero to three further cycles. The sampling strobe can be moved so that capture happens up to two cycles before the nominal point or one cycle after it. The captured bit and a one-cycle valid pulse go to the receive shift register.

The settings come from one 32-bit control word, and only three 2-bit fields of it are decoded. The settings are meant to stay fixed for a burst. Every delay stage, including the synchronizer, is cleared to the idle level when a burst starts, so no bit left over from the previous burst reaches the pad or the capture register. A slower serial clock, from a division of 6 or more, is normally paired with a longer input delay.

Top module: `spi_io_timing`

## Requirements
- R1: `mosi_pad` equals `mosi_src` as it stood N cycles earlier, where N is the value of control bits 17:16. With N = 0 the path is combinational within the same cycle.
- R2: Control bits 19:18 (M = 0..3) add M cycles to the receive path. For a given strobe, the captured bit is taken M cycles further back.
- R3: `miso_pad` is registered twice before the programmable delay. With the capture code set to 2 (nominal), a strobe sampled at edge t captures the `miso_pad` level sampled at edge t-2-M, and the result is visible after edge t+2.
- R4: Control bits 21:20 select the capture code K. A strobe sampled at edge t is acted on at edge t+K and captures the `miso_pad` level from edge t+K-4-M. Codes 0, 1, 2 and 3 therefore capture 2 cycles early, 1 cycle early, at the nominal point and 1 cycle late. With K = 0, `cap_valid` is high in the cycle after the strobe edge.
- R5: `cap_valid` is high for exactly one cycle per acted-on strobe. `cap_bit` keeps its last captured value between captures.
- R6: Reset and `burst_start` load every delay stage with the idle level. The idle level is 1 for both data directions and 0 for the strobe. After a start at edge f, any level sampled at or before edge f comes out as idle. After reset, `cap_valid` is 0 and `cap_bit` is 1.
- R7: At an edge where `burst_start` is high, no capture takes place: `cap_valid` goes to 0 and `cap_bit` goes to 1. Strobes already in the delay line at that edge are dropped.
- R8: Control bits outside 21:16 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock of the SPI master |
| rst_n | input | 1 | Asynchronous active-low reset |
| burst_start | input | 1 | One-cycle pulse at the start of a burst; flushes all stages |
| tcfg | input | 32 | Control word; bits 21:16 hold the three timing fields |
| mosi_src | input | 1 | Transmit bit from the shift register |
| mosi_pad | output | 1 | Delayed transmit bit to the pad |
| miso_pad | input | 1 | Receive bit from the pad, asynchronous |
| samp_strobe | input | 1 | Nominal sampling strobe from the clock generator |
| cap_valid | output | 1 | One-cycle pulse when a bit has been captured |
| cap_bit | output | 1 | Last captured receive bit |

## Verification
The hardest case to reach is a burst start that lands while strobes and data are still moving through the longest paths: capture code 3 together with input delay 3. Here the flush must drop a strobe in flight and replace old receive bits with the idle level. The stimulus runs many short bursts with a dense random strobe and a fresh random control word for each burst. The first bursts are directed: all fields zero, then all fields at their maximum. A strobe is also forced onto the start edge of several bursts. The expected values are computed from a history of every driven input and every flush edge, so each register's flush window is predicted without modelling the register chain.

// File: rtl/spi_iot_pkg.sv
package spi_iot_pkg;
  localparam int CFG_W      = 32;
  localparam int FLD_W      = 2;
  localparam int OUT_LSB    = 16;
  localparam int IN_LSB     = 18;
  localparam int CAP_LSB    = 20;
  localparam int MAX_DLY    = (1 << FLD_W) - 1;
  localparam int SYNC_STAGES = 2;
  localparam int CAP_LEAD   = 2;

  function automatic logic [FLD_W-1:0] out_dly(input logic [CFG_W-1:0] cfg);
    return cfg[OUT_LSB +: FLD_W];
  endfunction

  function automatic logic [FLD_W-1:0] in_dly(input logic [CFG_W-1:0] cfg);
    return cfg[IN_LSB +: FLD_W];
  endfunction

  // Capture code equals the tap of the strobe line: code 2 lines up with
  // the fixed CAP_LEAD data alignment, lower codes capture earlier.
  function automatic logic [FLD_W-1:0] cap_tap(input logic [CFG_W-1:0] cfg);
    return cfg[CAP_LSB +: FLD_W];
  endfunction
endpackage

// File: rtl/spi_iot_delay_line.sv
module spi_iot_delay_line #(
  parameter int DEPTH    = 3,
  parameter bit IDLE_LVL = 1'b1,
  parameter int SEL_W    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             din,
  input  logic [SEL_W-1:0] sel,
  output logic             dout
);
  logic [DEPTH-1:0] q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q[i] <= IDLE_LVL;
      else if (flush) q[i] <= IDLE_LVL;
      else if (i == 0) q[i] <= din;
      else            q[i] <= q[(i == 0) ? 0 : i-1];
    end
  end

  always_comb begin
    dout = din;
    for (int k = 1; k <= DEPTH; k++) begin
      if (int'(sel) == k) dout = q[k-1];
    end
  end

  assert_flush_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (q == {DEPTH{IDLE_LVL}}))
    else $error("delay stages not idle after flush");
endmodule

// File: rtl/spi_iot_capture.sv
module spi_iot_capture #(
  parameter bit IDLE_LVL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic flush,
  input  logic strobe_tap,
  input  logic data_in,
  output logic cap_valid,
  output logic cap_bit
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_valid <= 1'b0;
      cap_bit   <= IDLE_LVL;
    end else if (flush) begin
      cap_valid <= 1'b0;
      cap_bit   <= IDLE_LVL;
    end else begin
      cap_valid <= strobe_tap;
      if (strobe_tap) cap_bit <= data_in;
    end
  end

  assert_flush_no_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!cap_valid && cap_bit == IDLE_LVL))
    else $error("capture at flush edge");

  assert_hold_between_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && !strobe_tap) |=> (!cap_valid && $stable(cap_bit)))
    else $error("captured bit moved without strobe");
endmodule

// File: rtl/spi_io_timing.sv
module spi_io_timing
  import spi_iot_pkg::*;
#(
  parameter bit IDLE_LVL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             burst_start,
  input  logic [CFG_W-1:0] tcfg,
  input  logic             mosi_src,
  output logic             mosi_pad,
  input  logic             miso_pad,
  input  logic             samp_strobe,
  output logic             cap_valid,
  output logic             cap_bit
);
  localparam int STRB_DEPTH = CAP_LEAD + 1;
  localparam int SYNC_SW    = $clog2(SYNC_STAGES + 1);
  localparam int ALGN_SW    = $clog2(CAP_LEAD + 1);

  logic [FLD_W-1:0]   f_out, f_in, f_cap;
  logic [SYNC_SW-1:0] sync_sel;
  logic [ALGN_SW-1:0] algn_sel;
  logic miso_sync, miso_dly, miso_aligned, strobe_tap;
  logic armed_q;

  assign f_out    = out_dly(tcfg);
  assign f_in     = in_dly(tcfg);
  assign f_cap    = cap_tap(tcfg);
  assign sync_sel = SYNC_SW'(SYNC_STAGES);
  assign algn_sel = ALGN_SW'(CAP_LEAD);

  spi_iot_delay_line #(.DEPTH(MAX_DLY), .IDLE_LVL(IDLE_LVL), .SEL_W(FLD_W)) u_mosi (
    .clk(clk), .rst_n(rst_n), .flush(burst_start),
    .din(mosi_src), .sel(f_out), .dout(mosi_pad));

  spi_iot_delay_line #(.DEPTH(SYNC_STAGES), .IDLE_LVL(IDLE_LVL), .SEL_W(SYNC_SW)) u_sync (
    .clk(clk), .rst_n(rst_n), .flush(burst_start),
    .din(miso_pad), .sel(sync_sel), .dout(miso_sync));

  spi_iot_delay_line #(.DEPTH(MAX_DLY), .IDLE_LVL(IDLE_LVL), .SEL_W(FLD_W)) u_indly (
    .clk(clk), .rst_n(rst_n), .flush(burst_start),
    .din(miso_sync), .sel(f_in), .dout(miso_dly));

  spi_iot_delay_line #(.DEPTH(CAP_LEAD), .IDLE_LVL(IDLE_LVL), .SEL_W(ALGN_SW)) u_align (
    .clk(clk), .rst_n(rst_n), .flush(burst_start),
    .din(miso_dly), .sel(algn_sel), .dout(miso_aligned));

  spi_iot_delay_line #(.DEPTH(STRB_DEPTH), .IDLE_LVL(1'b0), .SEL_W(FLD_W)) u_strb (
    .clk(clk), .rst_n(rst_n), .flush(burst_start),
    .din(samp_strobe), .sel(f_cap), .dout(strobe_tap));

  spi_iot_capture #(.IDLE_LVL(IDLE_LVL)) u_cap (
    .clk(clk), .rst_n(rst_n), .flush(burst_start),
    .strobe_tap(strobe_tap), .data_in(miso_aligned),
    .cap_valid(cap_valid), .cap_bit(cap_bit));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end

  assert_mosi_one_cycle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && f_out == 2'd1 && !$past(burst_start)) |-> (mosi_pad == $past(mosi_src)))
    else $error("transmit delay of one cycle broken");

  assert_early_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!burst_start && f_cap == 2'd0 && samp_strobe) |=> cap_valid)
    else $error("early capture missed");
endmodule

// File: tb/spi_io_timing_tb_top.sv
`timescale 1ns/1ps
module spi_io_timing_tb_top;
  localparam int  MAXC = 4096;
  localparam bit  IDLE = 1'b1;
  localparam int  NB   = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic burst_start = 1'b0;
  logic [31:0] tcfg = '0;
  logic mosi_src = 1'b1;
  logic miso_pad = 1'b1;
  logic samp_strobe = 1'b0;
  logic mosi_pad, cap_valid, cap_bit;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  int e      = 0;
  bit exp_bit = IDLE;

  bit m_h[MAXC], s_h[MAXC], src_h[MAXC], fl_h[MAXC];
  logic [31:0] cfg_h[MAXC];

  always #2.5 clk = ~clk;

  spi_io_timing #(.IDLE_LVL(IDLE)) dut_i (
    .clk(clk), .rst_n(rst_n), .burst_start(burst_start), .tcfg(tcfg),
    .mosi_src(mosi_src), .mosi_pad(mosi_pad), .miso_pad(miso_pad),
    .samp_strobe(samp_strobe), .cap_valid(cap_valid), .cap_bit(cap_bit));

  // Level seen at edge e of a signal first sampled at edge j (kind 0 miso,
  // 1 strobe, 2 transmit source); idle when any flush edge lies in [j, e-1].
  function automatic bit hv(input int kind, input int j, input int ee);
    bit idl;
    idl = (kind == 1) ? 1'b0 : IDLE;
    if (j < 0) return idl;
    for (int f = j; f < ee; f++) if (fl_h[f]) return idl;
    case (kind)
      0: return m_h[j];
      1: return s_h[j];
      default: return src_h[j];
    endcase
  endfunction

  task automatic chk(input bit act, input bit exp, input string tag, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s at cycle %0d: actual=%0b expected=%0b", tag, what, e, act, exp);
    end
  endtask

  task automatic step(input bit start, input logic [31:0] cfg, input bit force_strb);
    int n, k, mm, pe;
    bit sv;
    burst_start = start;
    tcfg        = cfg;
    mosi_src    = 1'($urandom);
    miso_pad    = 1'($urandom);
    samp_strobe = force_strb ? 1'b1 : (($urandom % 3) == 0);
    m_h[e] = miso_pad; s_h[e] = samp_strobe; src_h[e] = mosi_src;
    fl_h[e] = start;   cfg_h[e] = cfg;
    #1;
    n = int'(cfg[17:16]);
    chk(mosi_pad, (n == 0) ? mosi_src : hv(2, e - n, e), "R1/R6/R8", "mosi_pad");
    if (e == 0) begin
      chk(cap_valid, 1'b0, "R6", "cap_valid after reset");
      chk(cap_bit, IDLE, "R6", "cap_bit after reset");
    end else begin
      pe = e - 1;
      k  = int'(cfg_h[pe][21:20]);
      mm = int'(cfg_h[pe][19:18]);
      if (fl_h[pe]) begin
        exp_bit = IDLE;
        chk(cap_valid, 1'b0, "R7", "cap_valid at start edge");
        chk(cap_bit, IDLE, "R7", "cap_bit at start edge");
      end else begin
        sv = hv(1, pe - k, pe);
        if (sv) exp_bit = hv(0, pe - 4 - mm, pe);
        chk(cap_valid, sv, "R4/R5/R7", "cap_valid");
        chk(cap_bit, exp_bit, "R2/R3/R4/R5/R6", "cap_bit");
      end
    end
    e++;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R1..all actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] cfg;
    int len;
    void'($urandom(32'h1c4d7));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int b = 0; b < NB; b++) begin
      if (b == 0)      cfg = 32'h0;                      // all codes zero
      else if (b == 1) cfg = 32'h003F_0000;              // longest paths
      else if (b == 2) cfg = 32'hFFC0_FFFF;              // R8: fields zero, rest set
      else if (b == 3) cfg = 32'h0020_0000;              // R3: nominal capture
      else             cfg = $urandom;
      len = (b < 6) ? 12 : 6 + int'($urandom % 30);
      for (int c = 0; c < len; c++) begin
        if (e < MAXC - 1)
          step(c == 0 && b > 0, cfg, (c == 0 && (b % 3) == 1) || (c == 1 && b == 3));
      end
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule